// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a 32-bit bus master and a 512-byte window of peripheral registers. The registers in the window are not all the same width. Each aligned 4-byte slot holds registers of one native width: 1, 2 or 4 bytes, or nothing at all. The master may issue byte, halfword or word accesses at any naturally aligned offset. The adapter turns each one into a sequence of native-width cycles on a downstream register port.

If the master's access is narrower than the register, the adapter reads the whole native register and picks out the addressed lanes. For a write, it merges the new lanes into the value it read and writes the register back. If the access is wider than the register, the adapter splits it into several native-width cycles at ascending addresses. In every case the byte at the lowest address is the most significant (big-endian).

The bus ready pulse comes only after the whole sequence has finished. Accesses outside the window, accesses to unmapped slots and accesses with an illegal size all complete at once. They return zero and raise the error flag.

Top module: `mwa_adapter`

## Requirements
- R1: An access whose offset is 0x200 or higher completes with up_err=1 and up_rdata=0, and issues no downstream cycle.
- R2: The native width comes from the slot index addr[8:2]. Width 4 applies at slots 20, 23, 26, ..., 47 (every third slot). Width 1 applies at slots 0–11, 16, 50, 68, 76 and 80–127. Width 0 (unmapped) applies at slots 51–63, 69–71 and 77–79. Every other slot has width 2. Every downstream cycle uses the native size of its slot (dn_size 0=byte, 1=half, 2=word). An access to an unmapped slot completes with up_err=1 and up_rdata=0, and issues no downstream cycle.
- R3: When the access size equals the native width, exactly one downstream cycle is issued, with the same address, size and data. A read returns dn_rdata.
- R4: A read narrower than the register issues one read of the native register at the address aligned to the native width. The addressed lanes are returned right-justified, and the lowest byte address is the most significant lane.
- R5: A write narrower than the register issues a read of the native register and then a write to the same address. Only the addressed bytes change.
- R6: An access wider than the register is split into (access bytes / native width) cycles at ascending addresses, starting at the access address. The first cycle carries the most significant part. A read concatenates the parts in that order.
- R7: up_ready is a single-cycle pulse given once per accepted access, after the last downstream cycle. up_rdata is zero for writes.
- R8: An access with up_size=3 completes with up_err=1 and up_rdata=0, and issues no downstream cycle.
- R9: While dn_valid is high and dn_ack is low, dn_addr, dn_size, dn_we and dn_wdata hold their values.
- R10: During and straight after reset, up_ready, up_err and dn_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Bus request, held until up_ready |
| up_we | input | 1 | 1 = write |
| up_size | input | 2 | 0 byte, 1 half, 2 word |
| up_addr | input | ADDR_W | Byte offset into the window |
| up_wdata | input | 32 | Write value, right-justified |
| up_ready | output | 1 | Completion pulse |
| up_rdata | output | 32 | Read value, right-justified, valid with up_ready |
| up_err | output | 1 | Error flag, valid with up_ready |
| dn_valid | output | 1 | Downstream cycle request |
| dn_we | output | 1 | Downstream write |
| dn_size | output | 2 | Native size of the downstream cycle |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_wdata | output | 32 | Downstream write value, right-justified |
| dn_rdata | input | 32 | Downstream read value, right-justified |
| dn_ack | input | 1 | Downstream cycle completes at this clock edge |

## Verification
The assertions take it for granted that the master keeps up_valid and its fields steady until up_ready, and that every access is naturally aligned to its own size. Given those two assumptions, no split or merge sequence can cross a slot boundary. They also assume that dn_ack is only driven while dn_valid is high. The stimulus meets these assumptions by using aligned offsets only and dropping the request in the cycle where up_ready is seen. Its downstream model acknowledges only pending cycles, after a configurable number of wait cycles.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    K_DIRECT = 2'd0,
    K_SPLIT  = 2'd1,
    K_MERGE  = 2'd2,
    K_FAULT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  // bus size code to byte count; code 3 is illegal (0 bytes)
  function automatic logic [2:0] bytes_of(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] code_of(input logic [2:0] nb);
    case (nb)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] lane_mask(input logic [2:0] nb);
    case (nb)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // native width of one 4-byte slot of the window
  function automatic logic [2:0] slot_width(input int unsigned slot);
    if (slot <= 11)      return 3'd1;
    else if (slot <= 15) return 3'd2;
    else if (slot == 16) return 3'd1;
    else if (slot <= 19) return 3'd2;
    else if (slot <= 47) return (((slot - 20) % 3) == 0) ? 3'd4 : 3'd2;
    else if (slot <= 49) return 3'd2;
    else if (slot == 50) return 3'd1;
    else if (slot <= 63) return 3'd0;
    else if (slot <= 67) return 3'd2;
    else if (slot == 68) return 3'd1;
    else if (slot <= 71) return 3'd0;
    else if (slot <= 75) return 3'd2;
    else if (slot == 76) return 3'd1;
    else if (slot <= 79) return 3'd0;
    else                 return 3'd1;
  endfunction

  // bit shift of an ab-byte lane at offset off inside an nb-byte register
  function automatic logic [5:0] lane_shift(input logic [2:0] nb, input logic [2:0] ab,
                                            input logic [1:0] off);
    logic [1:0] ofs;
    logic [2:0] gap;
    ofs = off & (nb[1:0] - 2'd1);
    gap = nb - ab - {1'b0, ofs};
    return {gap, 3'b000};
  endfunction

  function automatic logic [BUS_W-1:0] lane_pick(input logic [BUS_W-1:0] native,
                                                 input logic [2:0] nb, input logic [2:0] ab,
                                                 input logic [1:0] off);
    return (native >> lane_shift(nb, ab, off)) & lane_mask(ab);
  endfunction

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] native,
                                                  input logic [2:0] nb, input logic [2:0] ab,
                                                  input logic [1:0] off,
                                                  input logic [BUS_W-1:0] val);
    logic [BUS_W-1:0] m;
    m = lane_mask(ab) << lane_shift(nb, ab, off);
    return (native & ~m) | ((val & lane_mask(ab)) << lane_shift(nb, ab, off));
  endfunction

  // part number beat of an ab-byte value cut into nb-byte parts, high part first
  function automatic logic [BUS_W-1:0] part_of(input logic [BUS_W-1:0] val,
                                               input logic [2:0] ab, input logic [2:0] nb,
                                               input logic [1:0] beat);
    logic [2:0] used;
    logic [2:0] gap;
    used = 3'(nb * (3'({1'b0, beat}) + 3'd1));
    gap  = ab - used;
    return (val >> {gap, 3'b000}) & lane_mask(nb);
  endfunction

endpackage

// File: rtl/mwa_width_map.sv
module mwa_width_map #(
  parameter int SLOT_W = 7
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [2:0]        width_o
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [2:0] tbl [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign tbl[g] = mwa_pkg::slot_width(g);
  end

  assign width_o = tbl[slot_i];
endmodule

// File: rtl/mwa_planner.sv
module mwa_planner
  import mwa_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        width_i,
  output kind_e             kind_o,
  output logic [2:0]        beats_o,
  output logic [2:0]        abytes_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int WIN_AW = $clog2(WIN_BYTES);

  logic       in_range;
  logic [2:0] ab;

  assign in_range = (addr_i[ADDR_W-1:WIN_AW] == '0);
  assign ab       = bytes_of(size_i);
  assign abytes_o = ab;

  always_comb begin
    kind_o  = K_FAULT;
    beats_o = 3'd0;
    base_o  = addr_i;
    if (in_range && (ab != 3'd0) && (width_i != 3'd0)) begin
      if (width_i == ab) begin
        kind_o  = K_DIRECT;
        beats_o = 3'd1;
      end else if (width_i > ab) begin
        kind_o  = K_MERGE;
        beats_o = 3'd1;
        base_o  = addr_i & ~ADDR_W'(width_i - 3'd1);
      end else begin
        kind_o  = K_SPLIT;
        beats_o = (width_i == 3'd1) ? ab : {1'b0, ab[2:1]};
      end
    end
  end
endmodule

// File: rtl/mwa_lane.sv
module mwa_lane
  import mwa_pkg::*;
(
  input  logic [BUS_W-1:0] native_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [2:0]       nbytes_i,
  input  logic [2:0]       abytes_i,
  input  logic [1:0]       off_i,
  input  logic [1:0]       beat_i,
  output logic [BUS_W-1:0] pick_o,
  output logic [BUS_W-1:0] merged_o,
  output logic [BUS_W-1:0] part_o
);
  assign pick_o   = lane_pick(native_i, nbytes_i, abytes_i, off_i);
  assign merged_o = lane_merge(native_i, nbytes_i, abytes_i, off_i, wdata_i);
  assign part_o   = part_of(wdata_i, abytes_i, nbytes_i, beat_i);
endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_we,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic              up_ready,
  output logic [31:0]       up_rdata,
  output logic              up_err,
  output logic              dn_valid,
  output logic              dn_we,
  output logic [1:0]        dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              dn_ack
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int SLOT_W = WIN_AW - 2;

  // lookup and planning of the incoming access
  logic [2:0]        map_w;
  kind_e             plan_kind;
  logic [2:0]        plan_beats;
  logic [2:0]        plan_ab;
  logic [ADDR_W-1:0] plan_base;

  mwa_width_map #(.SLOT_W(SLOT_W)) u_map (
    .slot_i  (up_addr[WIN_AW-1:2]),
    .width_o (map_w)
  );

  mwa_planner #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_plan (
    .addr_i   (up_addr),
    .size_i   (up_size),
    .width_i  (map_w),
    .kind_o   (plan_kind),
    .beats_o  (plan_beats),
    .abytes_o (plan_ab),
    .base_o   (plan_base)
  );

  // sequence state
  st_e               st_q;
  kind_e             kind_q;
  logic              we_q;
  logic              wph_q;
  logic              err_q;
  logic [2:0]        ab_q;
  logic [2:0]        nb_q;
  logic [1:0]        off_q;
  logic [2:0]        beats_q;
  logic [2:0]        beat_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       acc_q;
  logic [31:0]       wdata_q;

  // named events for the checker
  logic accept_w;
  logic fault_w;
  logic beat_fire_w;
  logic last_beat_w;
  logic split_w;
  logic merge_wr_w;

  assign accept_w    = (st_q == ST_IDLE) && up_valid;
  assign fault_w     = accept_w && (plan_kind == K_FAULT);
  assign beat_fire_w = (st_q == ST_BEAT) && dn_ack;
  assign split_w     = (st_q == ST_BEAT) && (kind_q == K_SPLIT);
  assign merge_wr_w  = (st_q == ST_BEAT) && (kind_q == K_MERGE) && wph_q;
  assign last_beat_w = beat_fire_w &&
                       ((kind_q == K_DIRECT) ||
                        ((kind_q == K_SPLIT) && (beat_q == beats_q - 3'd1)) ||
                        ((kind_q == K_MERGE) && (wph_q || !we_q)));

  // lane arithmetic
  logic [31:0] lane_pick_w;
  logic [31:0] lane_merge_w;
  logic [31:0] lane_part_w;
  logic [31:0] rd_native;

  mwa_lane u_lane (
    .native_i (acc_q),
    .wdata_i  (wdata_q),
    .nbytes_i (nb_q),
    .abytes_i (ab_q),
    .off_i    (off_q),
    .beat_i   (beat_q[1:0]),
    .pick_o   (lane_pick_w),
    .merged_o (lane_merge_w),
    .part_o   (lane_part_w)
  );

  assign rd_native = dn_rdata & lane_mask(nb_q);

  // downstream port
  assign dn_valid = (st_q == ST_BEAT);
  assign dn_size  = code_of(nb_q);
  assign dn_addr  = base_q + ADDR_W'(beat_q) * ADDR_W'(nb_q);

  always_comb begin
    dn_we    = 1'b0;
    dn_wdata = '0;
    case (kind_q)
      K_DIRECT: begin
        dn_we    = we_q;
        dn_wdata = we_q ? (wdata_q & lane_mask(nb_q)) : '0;
      end
      K_SPLIT: begin
        dn_we    = we_q;
        dn_wdata = we_q ? lane_part_w : '0;
      end
      K_MERGE: begin
        dn_we    = wph_q;
        dn_wdata = wph_q ? (lane_merge_w & lane_mask(nb_q)) : '0;
      end
      default: ;
    endcase
  end

  // upstream response
  assign up_ready = (st_q == ST_DONE);
  assign up_err   = up_ready && err_q;
  assign up_rdata = (up_ready && !err_q && !we_q) ?
                    ((kind_q == K_MERGE) ? lane_pick_w : acc_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_FAULT;
      we_q    <= 1'b0;
      wph_q   <= 1'b0;
      err_q   <= 1'b0;
      ab_q    <= 3'd0;
      nb_q    <= 3'd1;
      off_q   <= 2'd0;
      beats_q <= 3'd0;
      beat_q  <= 3'd0;
      base_q  <= '0;
      acc_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (up_valid) begin
            kind_q  <= plan_kind;
            we_q    <= up_we;
            wph_q   <= 1'b0;
            err_q   <= (plan_kind == K_FAULT);
            ab_q    <= plan_ab;
            nb_q    <= (map_w == 3'd0) ? 3'd1 : map_w;
            off_q   <= up_addr[1:0];
            beats_q <= plan_beats;
            beat_q  <= 3'd0;
            base_q  <= plan_base;
            acc_q   <= '0;
            wdata_q <= up_wdata;
            st_q    <= (plan_kind == K_FAULT) ? ST_DONE : ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (dn_ack) begin
            case (kind_q)
              K_DIRECT: acc_q <= rd_native;
              K_SPLIT: begin
                if (!we_q) acc_q <= (acc_q << {nb_q, 3'b000}) | rd_native;
                beat_q <= beat_q + 3'd1;
              end
              K_MERGE: begin
                if (!wph_q) acc_q <= rd_native;
                wph_q <= 1'b1;
              end
              default: ;
            endcase
            if (last_beat_w) st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwa_adapter_chk.sv
module mwa_adapter_chk
  import mwa_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_ready,
  input logic              up_err,
  input logic [31:0]       up_rdata,
  input logic              dn_valid,
  input logic              dn_ack,
  input logic              dn_we,
  input logic [1:0]        dn_size,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [31:0]       dn_wdata,
  input logic              fault_w,
  input logic              beat_fire_w,
  input logic              last_beat_w,
  input logic              split_w,
  input logic              merge_wr_w
);
  localparam int WIN_AW = $clog2(WIN_BYTES);

  // R1 R2 R8: a faulting access answers next cycle without touching the port
  a_r1_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_w |=> (up_ready && up_err && !dn_valid));

  // R1: error responses carry zero data
  a_r1_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && up_err) |-> (up_rdata == 32'd0));

  // R2: every downstream cycle uses the native size of its slot
  a_r2_native_size: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_size == code_of(slot_width(32'(dn_addr[WIN_AW-1:2])))));

  // R5: the write-back of a merge follows a completed read
  a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(merge_wr_w) |-> $past(beat_fire_w));

  // R6: split parts go to ascending addresses
  a_r6_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire_w && split_w && !last_beat_w) |=> (dn_valid && (dn_addr > $past(dn_addr))));

  // R7: completion is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready);

  // R9: a waiting downstream cycle holds its fields
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_size) &&
                               $stable(dn_we) && $stable(dn_wdata)));
endmodule

bind mwa_adapter mwa_adapter_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_ready    (up_ready),
  .up_err      (up_err),
  .up_rdata    (up_rdata),
  .dn_valid    (dn_valid),
  .dn_ack      (dn_ack),
  .dn_we       (dn_we),
  .dn_size     (dn_size),
  .dn_addr     (dn_addr),
  .dn_wdata    (dn_wdata),
  .fault_w     (fault_w),
  .beat_fire_w (beat_fire_w),
  .last_beat_w (last_beat_w),
  .split_w     (split_w),
  .merge_wr_w  (merge_wr_w)
);

// File: tb/mwa_adapter_tb.sv
`timescale 1ns/1ps
module mwa_adapter_tb_top;
  localparam int AW = 12;
  localparam int NV = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_valid = 1'b0;
  logic          up_we = 1'b0;
  logic [1:0]    up_size = 2'd0;
  logic [AW-1:0] up_addr = '0;
  logic [31:0]   up_wdata = '0;
  logic          up_ready;
  logic [31:0]   up_rdata;
  logic          up_err;
  logic          dn_valid;
  logic          dn_we;
  logic [1:0]    dn_size;
  logic [AW-1:0] dn_addr;
  logic [31:0]   dn_wdata;
  logic [31:0]   dn_rdata;
  logic          dn_ack;

  always #2 clk = ~clk;

  mwa_adapter #(.ADDR_W(AW), .WIN_BYTES(512)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_we(up_we), .up_size(up_size), .up_addr(up_addr),
    .up_wdata(up_wdata), .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
    .dn_valid(dn_valid), .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference width of a byte offset (0 = out of window or unmapped)
  function automatic int ref_width(input logic [AW-1:0] a);
    int s;
    if (a >= 12'h200) return 0;
    s = int'(a[8:2]);
    case (s) inside
      [0:11], 16, 50, 68, 76, [80:127]:           return 1;
      20, 23, 26, 29, 32, 35, 38, 41, 44, 47:     return 4;
      [51:63], [69:71], [77:79]:                  return 0;
      default:                                    return 2;
    endcase
  endfunction

  function automatic int ref_bytes(input logic [1:0] sz);
    return (sz == 2'd3) ? 0 : (1 << sz);
  endfunction

  // downstream register model: byte array, big-endian
  logic [7:0] mem    [512];
  logic [7:0] shadow [512];
  int stall = 0;
  int wait_cnt = 0;

  assign dn_ack = dn_valid && (wait_cnt >= stall);

  always_comb begin
    dn_rdata = '0;
    for (int k = 0; k < (1 << dn_size); k++)
      dn_rdata = (dn_rdata << 8) | 32'(mem[9'(dn_addr) + 9'(k)]);
  end

  always @(posedge clk) begin
    if (dn_valid && !dn_ack) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
  end

  // beat monitor
  int            beat_cnt;
  bit            size_bad;
  bit            first_seen;
  logic [AW-1:0] first_addr;
  logic [31:0]   first_wdata;
  bit            held = 0;
  logic [AW-1:0] p_addr;
  logic [1:0]    p_size;
  logic          p_we;
  logic [31:0]   p_wdata;

  always @(negedge clk) begin
    if (dn_valid) begin
      if (held)
        chk((dn_addr == p_addr) && (dn_size == p_size) && (dn_we == p_we) &&
            (dn_wdata == p_wdata), "R9 held fields", 32'(dn_addr), 32'(p_addr));
      held    = !dn_ack;
      p_addr  = dn_addr;
      p_size  = dn_size;
      p_we    = dn_we;
      p_wdata = dn_wdata;
      if (dn_ack) begin
        beat_cnt++;
        if ((1 << dn_size) != ref_width(dn_addr)) size_bad = 1;
        if (!first_seen) begin
          first_seen  = 1;
          first_addr  = dn_addr;
          first_wdata = dn_wdata;
        end
        if (dn_we)
          for (int k = 0; k < (1 << dn_size); k++)
            mem[9'(dn_addr) + 9'(k)] = 8'(dn_wdata >> (8 * ((1 << dn_size) - 1 - k)));
      end
    end else begin
      held = 0;
    end
  end

  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz, input logic we,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    int guard;
    beat_cnt   = 0;
    size_bad   = 0;
    first_seen = 0;
    @(negedge clk);
    up_addr  = a;
    up_size  = sz;
    up_we    = we;
    up_wdata = wd;
    up_valid = 1'b1;
    guard    = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!up_ready && guard < 300);
    if (!up_ready) chk(0, "R7 ready timeout", 32'(guard), 32'd0);
    rd       = up_rdata;
    er       = up_err;
    up_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [AW-1:0] a, input logic [1:0] sz, input logic we,
                         input logic [31:0] wd);
    int w, s, eb;
    bit fault;
    string tag;
    logic [31:0] exp_rd, rd, exp_part;
    logic [AW-1:0] exp_first;
    logic er;
    w     = ref_width(a);
    s     = ref_bytes(sz);
    fault = (w == 0) || (s == 0);
    if (fault) tag = (a >= 12'h200) ? "R1" : ((s == 0) ? "R8" : "R2");
    else if (w == s) tag = "R3";
    else if (w > s) tag = we ? "R5" : "R4";
    else tag = "R6";
    eb = fault ? 0 : ((w == s) ? 1 : ((w > s) ? (we ? 2 : 1) : s / w));
    exp_first = (w >= s) ? (a & ~AW'(w - 1)) : a;
    exp_rd = '0;
    if (!fault && !we)
      for (int k = 0; k < s; k++) exp_rd = (exp_rd << 8) | 32'(shadow[9'(a) + 9'(k)]);
    access(a, sz, we, wd, rd, er);
    chk(er == fault, {tag, " error flag"}, 32'(er), 32'(fault));
    chk(beat_cnt == eb, {tag, " beat count"}, 32'(beat_cnt), 32'(eb));
    chk(rd == exp_rd, {tag, " read data"}, rd, exp_rd);
    if (!fault) begin
      chk(!size_bad, "R2 native size", 32'(size_bad), 32'd0);
      chk(first_addr == exp_first, {tag, " first address"}, 32'(first_addr), 32'(exp_first));
      if (we && w < s) begin
        exp_part = (wd >> (8 * (s - w))) & ((w == 1) ? 32'hFF : 32'hFFFF);
        chk(first_wdata == exp_part, "R6 high part first", first_wdata, exp_part);
      end
      if (we)
        for (int k = 0; k < s; k++) shadow[9'(a) + 9'(k)] = 8'(wd >> (8 * (s - 1 - k)));
    end
  endtask

  // addr, size, we, wdata
  localparam logic [46:0] VECS [NV] = '{
    {12'h050, 2'd2, 1'b1, 32'hA1B2C3D4},
    {12'h050, 2'd2, 1'b0, 32'h0},
    {12'h051, 2'd0, 1'b0, 32'h0},
    {12'h052, 2'd0, 1'b1, 32'hFFFFFF5E},
    {12'h050, 2'd2, 1'b0, 32'h0},
    {12'h052, 2'd1, 1'b0, 32'h0},
    {12'h050, 2'd1, 1'b1, 32'h00001122},
    {12'h050, 2'd2, 1'b0, 32'h0},
    {12'h030, 2'd2, 1'b1, 32'hCAFEF00D},
    {12'h030, 2'd2, 1'b0, 32'h0},
    {12'h033, 2'd0, 1'b0, 32'h0},
    {12'h032, 2'd0, 1'b1, 32'h00000077},
    {12'h030, 2'd1, 1'b0, 32'h0},
    {12'h008, 2'd2, 1'b1, 32'h01234567},
    {12'h008, 2'd2, 1'b0, 32'h0},
    {12'h00A, 2'd1, 1'b0, 32'h0},
    {12'h146, 2'd1, 1'b1, 32'h0000BEEF},
    {12'h147, 2'd0, 1'b0, 32'h0},
    {12'h0CC, 2'd2, 1'b0, 32'h0},
    {12'h0CD, 2'd0, 1'b1, 32'h000000AA},
    {12'h200, 2'd2, 1'b0, 32'h0},
    {12'h204, 2'd1, 1'b1, 32'h00001234},
    {12'h050, 2'd3, 1'b1, 32'hFFFFFFFF},
    {12'h054, 2'd2, 1'b0, 32'h0},
    {12'h141, 2'd0, 1'b1, 32'h0000003C},
    {12'h141, 2'd0, 1'b0, 32'h0}
  };

  initial begin
    int mism;
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!up_ready && !up_err && !dn_valid, "R10 in reset", {29'd0, up_ready, up_err, dn_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!up_ready && !up_err && !dn_valid, "R10 after reset", {29'd0, up_ready, up_err, dn_valid}, 32'd0);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v][46:35], VECS[v][34:33], VECS[v][32], VECS[v][31:0]);

    // waiting downstream: fields must hold (R9) while sequences still complete
    stall = 2;
    run_vec(12'h010, 2'd2, 1'b1, 32'h89ABCDEF);
    run_vec(12'h010, 2'd2, 1'b0, 32'h0);
    run_vec(12'h05D, 2'd0, 1'b1, 32'h00000042);
    run_vec(12'h05C, 2'd2, 1'b0, 32'h0);
    stall = 0;

    // R5: no byte outside the written lanes changed anywhere in the window
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != shadow[i]) mism++;
    chk(mism == 0, "R5 window contents", 32'(mism), 32'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog act=%0d exp=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule